// File: doc/BRIEF.md
# Configuration Port Unlock and Banked Register Space

This block implements a byte-wide index/data pair of I/O ports that guards a small configuration register space. After reset the space is locked: data-port reads return 0xFF and data-port writes change no configuration register. Software unlocks it by writing the key byte 0x87 to the index port twice in a row. It then writes a register number to the index port and reads or writes that register through the data port. Writing 0xAA to the index port locks the space again.

The register space has two parts. The global part holds the device selector, which can be read and written, and read-only identity bytes for the chip and the vendor. The per-device part holds an enable bit, a 16-bit base address stored as two bytes, and an interrupt line number. It is banked: the device selector chooses which bank these registers reach. The host side is a simple synchronous strobe interface with an address, write data and combinational read data.

Top module: `cfg_port_unlock`

## Requirements
- R1: After reset the space is locked, the device selector is 0, every bank holds enable 0, base 0x0000 and interrupt 0, the index register is 0, and a data-port read returns 0xFF.
- R2: The space unlocks only on the second of two consecutive 0x87 writes to the index port (address INDEX_PORT). A single 0x87 write leaves data reads at 0xFF.
- R3: While locked, an index-port write of any value other than 0x87 restarts the unlock sequence, so 0x87, another value, 0x87 does not unlock.
- R4: While unlocked, writing 0xAA to the index port locks the space. Any other index-port write, 0x87 included, stores the value as the selected register number.
- R5: A read returns 0xFF when the space is locked, when the address is the index port, or when the address is neither INDEX_PORT nor INDEX_PORT+1 (the data port).
- R6: Register 0x07 holds the device selector and reads back zero-extended. A data write of a value of NUM_LDEV or more leaves it unchanged.
- R7: Registers 0x30 (enable, bit 0 only, other bits read 0), 0x60 (base high byte), 0x61 (base low byte) and 0x70 (interrupt number, low 4 bits, other bits read 0) reach only the bank chosen by the device selector. Each bank keeps its own values.
- R8: Registers 0x20/0x21 return the high and low bytes of CHIP_ID, 0x23/0x24 return the high and low bytes of VENDOR_ID, and 0x26 returns the low byte of INDEX_PORT. Writes to these registers have no effect.
- R9: A data-port write while the space is locked or half-unlocked changes no bank and no index register, and forces the device selector to 0.
- R10: While unlocked, a read of any register number not listed above returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_wr_i | input | 1 | Write strobe, one cycle per access |
| io_rd_i | input | 1 | Read strobe |
| io_addr_i | input | 16 | I/O address of the access |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data, valid in the cycle io_rd_i is high; 0xFF otherwise |

## Verification
The hardest states to reach are the half-unlocked state and the interplay between the lock sequence and the device selector. Two cases matter most: a data write that arrives between two key bytes, and a bank whose contents must survive a lock, a forced selector clear and a later unlock. Directed sequences build each of these orderings on purpose. A long stretch of weighted random traffic follows, biased towards key bytes, real register numbers and out-of-range selector values, so that unlocks, relocks and cross-bank writes interleave often.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam logic [7:0] UNLOCK_KEY   = 8'h87;
  localparam logic [7:0] LOCK_KEY     = 8'hAA;

  localparam logic [7:0] REG_LDN      = 8'h07;
  localparam logic [7:0] REG_CHIP_HI  = 8'h20;
  localparam logic [7:0] REG_CHIP_LO  = 8'h21;
  localparam logic [7:0] REG_VEND_HI  = 8'h23;
  localparam logic [7:0] REG_VEND_LO  = 8'h24;
  localparam logic [7:0] REG_PORT_SEL = 8'h26;
  localparam logic [7:0] REG_DEV_EN   = 8'h30;
  localparam logic [7:0] REG_BASE_HI  = 8'h60;
  localparam logic [7:0] REG_BASE_LO  = 8'h61;
  localparam logic [7:0] REG_IRQ      = 8'h70;

  localparam int IRQ_W  = 4;
  localparam int BASE_W = 16;

  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_ARMED  = 2'd1,
    ST_OPEN   = 2'd2
  } lock_state_e;

  typedef struct packed {
    logic              en;
    logic [BASE_W-1:0] base;
    logic [IRQ_W-1:0]  irq;
  } bank_t;

  function automatic logic is_bank_reg(input logic [7:0] r);
    return (r == REG_DEV_EN) || (r == REG_BASE_HI) ||
           (r == REG_BASE_LO) || (r == REG_IRQ);
  endfunction
endpackage

// File: rtl/cfg_unlock_fsm.sv
module cfg_unlock_fsm
  import cfg_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_wr_i,
  input  logic [7:0] wdata_i,
  output logic       open_o,
  output logic [7:0] reg_sel_o
);
  lock_state_e state_q, state_d;
  logic [7:0]  idx_q, idx_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    if (idx_wr_i) begin
      unique case (state_q)
        ST_LOCKED: state_d = (wdata_i == UNLOCK_KEY) ? ST_ARMED : ST_LOCKED;
        ST_ARMED:  state_d = (wdata_i == UNLOCK_KEY) ? ST_OPEN  : ST_LOCKED;
        ST_OPEN: begin
          if (wdata_i == LOCK_KEY) state_d = ST_LOCKED;
          else                     idx_d   = wdata_i;
        end
        default:   state_d = ST_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOCKED;
      idx_q   <= 8'h00;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign open_o    = (state_q == ST_OPEN);
  assign reg_sel_o = idx_q;

  // R2: a write seen in the locked state can never open the space directly
  a_r2_no_single_unlock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOCKED && idx_wr_i) |=> !open_o);

  // R3: a non-key index write while not open restarts the sequence
  a_r3_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open_o && idx_wr_i && wdata_i != UNLOCK_KEY) |=> (state_q == ST_LOCKED));

  // R4: exit byte locks
  a_r4_exit_locks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && idx_wr_i && wdata_i == LOCK_KEY) |=> !open_o);

  // R4: index register only moves while open
  a_r4_idx_hold_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open_o) |=> $stable(reg_sel_o));
endmodule

// File: rtl/cfg_ldev_bank.sv
module cfg_ldev_bank
  import cfg_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] reg_i,
  input  logic [7:0] wdata_i,
  output bank_t      bank_o
);
  bank_t bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= '0;
    end else if (wr_i) begin
      unique case (reg_i)
        REG_DEV_EN:  bank_q.en         <= wdata_i[0];
        REG_BASE_HI: bank_q.base[15:8] <= wdata_i;
        REG_BASE_LO: bank_q.base[7:0]  <= wdata_i;
        REG_IRQ:     bank_q.irq        <= wdata_i[IRQ_W-1:0];
        default: ;
      endcase
    end
  end

  assign bank_o = bank_q;

  // R7, R9: an unselected or blocked bank keeps its contents
  a_r7_bank_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i) |=> $stable(bank_o));
endmodule

// File: rtl/cfg_port_unlock.sv
module cfg_port_unlock
  import cfg_port_pkg::*;
#(
  parameter logic [15:0] INDEX_PORT = 16'h004E,
  parameter int          NUM_LDEV   = 8,
  parameter logic [15:0] CHIP_ID    = 16'h5A31,
  parameter logic [15:0] VENDOR_ID  = 16'h3C5A
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        io_wr_i,
  input  logic        io_rd_i,
  input  logic [15:0] io_addr_i,
  input  logic [7:0]  io_wdata_i,
  output logic [7:0]  io_rdata_o
);
  localparam int          LDEV_W    = (NUM_LDEV > 1) ? $clog2(NUM_LDEV) : 1;
  localparam logic [15:0] DATA_PORT = INDEX_PORT + 16'd1;

  logic       hit_idx, hit_dat, idx_wr, dat_wr, dat_rd;
  logic       cfg_open;
  logic [7:0] reg_sel;
  logic [LDEV_W-1:0] ldn_q;
  bank_t      banks [NUM_LDEV];
  bank_t      cur_bank;
  logic       ldn_wr_ok;

  assign hit_idx = (io_addr_i == INDEX_PORT);
  assign hit_dat = (io_addr_i == DATA_PORT);
  assign idx_wr  = io_wr_i && hit_idx;
  assign dat_wr  = io_wr_i && hit_dat;
  assign dat_rd  = io_rd_i && hit_dat && cfg_open;

  cfg_unlock_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idx_wr_i  (idx_wr),
    .wdata_i   (io_wdata_i),
    .open_o    (cfg_open),
    .reg_sel_o (reg_sel)
  );

  assign ldn_wr_ok = dat_wr && cfg_open && (reg_sel == REG_LDN) &&
                     (int'(io_wdata_i) < NUM_LDEV);

  // Locked data writes drop the selector back to device 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ldn_q <= '0;
    else if (dat_wr && !cfg_open) ldn_q <= '0;
    else if (ldn_wr_ok)          ldn_q <= io_wdata_i[LDEV_W-1:0];
  end

  for (genvar g = 0; g < NUM_LDEV; g++) begin : g_bank
    logic bank_wr;
    assign bank_wr = dat_wr && cfg_open && is_bank_reg(reg_sel) &&
                     (int'(ldn_q) == g);
    cfg_ldev_bank u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (bank_wr),
      .reg_i   (reg_sel),
      .wdata_i (io_wdata_i),
      .bank_o  (banks[g])
    );
  end

  always_comb begin
    cur_bank = '0;
    for (int i = 0; i < NUM_LDEV; i++)
      if (int'(ldn_q) == i) cur_bank = banks[i];
  end

  always_comb begin
    io_rdata_o = 8'hFF;
    if (dat_rd) begin
      unique case (reg_sel)
        REG_LDN:      io_rdata_o = 8'(ldn_q);
        REG_CHIP_HI:  io_rdata_o = CHIP_ID[15:8];
        REG_CHIP_LO:  io_rdata_o = CHIP_ID[7:0];
        REG_VEND_HI:  io_rdata_o = VENDOR_ID[15:8];
        REG_VEND_LO:  io_rdata_o = VENDOR_ID[7:0];
        REG_PORT_SEL: io_rdata_o = INDEX_PORT[7:0];
        REG_DEV_EN:   io_rdata_o = {7'b0, cur_bank.en};
        REG_BASE_HI:  io_rdata_o = cur_bank.base[15:8];
        REG_BASE_LO:  io_rdata_o = cur_bank.base[7:0];
        REG_IRQ:      io_rdata_o = 8'(cur_bank.irq);
        default:      io_rdata_o = 8'h00;
      endcase
    end
  end

  // R5: locked space reads as all ones
  a_r5_locked_reads_ff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && !cfg_open) |-> (io_rdata_o == 8'hFF));

  // R9: locked data write clears the selector
  a_r9_locked_wr_clears_ldn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_wr && !cfg_open) |=> (ldn_q == '0));

  // R6: out-of-range selector write is dropped
  a_r6_ldn_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_wr && cfg_open && reg_sel == REG_LDN && int'(io_wdata_i) >= NUM_LDEV)
    |=> $stable(ldn_q));

  // R6: selector never leaves the implemented range
  a_r6_ldn_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(ldn_q) < NUM_LDEV);
endmodule

// File: tb/tb_cfg_port_unlock.sv
`timescale 1ns/1ps
module tb_cfg_port_unlock;
  localparam logic [15:0] IDX  = 16'h004E;
  localparam logic [15:0] DAT  = 16'h004F;
  localparam int          NL   = 8;
  localparam logic [15:0] CHIP = 16'h5A31;
  localparam logic [15:0] VEND = 16'h3C5A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  int m_state;  // 0 locked, 1 armed, 2 open
  int m_idx, m_ldn;
  int m_en[NL], m_base[NL], m_irq[NL];

  always #2.5 clk = ~clk;

  cfg_port_unlock #(.INDEX_PORT(IDX), .NUM_LDEV(NL), .CHIP_ID(CHIP), .VENDOR_ID(VEND)) dut (
    .clk_i(clk), .rst_ni(rst_n), .io_wr_i(io_wr), .io_rd_i(io_rd),
    .io_addr_i(io_addr), .io_wdata_i(io_wdata), .io_rdata_o(io_rdata));

  task automatic model_reset();
    m_state = 0; m_idx = 0; m_ldn = 0;
    for (int i = 0; i < NL; i++) begin m_en[i] = 0; m_base[i] = 0; m_irq[i] = 0; end
  endtask

  function automatic int model_read(input logic [15:0] a);
    if (a != DAT || m_state != 2) return 8'hFF;
    case (m_idx)
      8'h07: return m_ldn;
      8'h20: return CHIP[15:8];
      8'h21: return CHIP[7:0];
      8'h23: return VEND[15:8];
      8'h24: return VEND[7:0];
      8'h26: return IDX[7:0];
      8'h30: return m_en[m_ldn];
      8'h60: return (m_base[m_ldn] >> 8) & 8'hFF;
      8'h61: return m_base[m_ldn] & 8'hFF;
      8'h70: return m_irq[m_ldn];
      default: return 0;
    endcase
  endfunction

  task automatic model_write(input logic [15:0] a, input int d);
    if (a == IDX) begin
      if (m_state != 2) m_state = (d == 8'h87) ? m_state + 1 : 0;
      else if (d == 8'hAA) m_state = 0;
      else m_idx = d;
    end else if (a == DAT) begin
      if (m_state != 2) m_ldn = 0;
      else case (m_idx)
        8'h07: if (d < NL) m_ldn = d;
        8'h30: m_en[m_ldn] = d & 1;
        8'h60: m_base[m_ldn] = (m_base[m_ldn] & 8'hFF) | (d << 8);
        8'h61: m_base[m_ldn] = (m_base[m_ldn] & 16'hFF00) | d;
        8'h70: m_irq[m_ldn] = d & 4'hF;
        default: ;
      endcase
    end
  endtask

  task automatic op(input bit rd, input bit wr, input logic [15:0] a,
                    input logic [7:0] d, input string tag);
    int exp;
    @(negedge clk);
    io_rd = rd; io_wr = wr; io_addr = a; io_wdata = d;
    #1;
    exp = rd ? model_read(a) : 8'hFF;
    checks++;
    if (int'(io_rdata) != exp) begin
      errors++;
      $display("FAIL %s addr=%h rdata=%h expected=%h", tag, a, io_rdata, exp[7:0]);
    end
    @(posedge clk);
    if (wr) model_write(a, d);
    #0.5;
    io_rd = 0; io_wr = 0;
  endtask

  task automatic wr_idx(input logic [7:0] d, input string t); op(0, 1, IDX, d, t); endtask
  task automatic wr_dat(input logic [7:0] d, input string t); op(0, 1, DAT, d, t); endtask
  task automatic rd_dat(input string t); op(1, 0, DAT, 8'h00, t); endtask
  task automatic rd_reg(input logic [7:0] r, input string t);
    wr_idx(r, t); rd_dat(t);
  endtask
  task automatic wr_reg(input logic [7:0] r, input logic [7:0] d, input string t);
    wr_idx(r, t); wr_dat(d, t);
  endtask
  task automatic unlock(input string t); wr_idx(8'h87, t); wr_idx(8'h87, t); endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd_dat("R1");
    unlock("R1");
    rd_reg(8'h07, "R1");
    rd_reg(8'h30, "R1"); rd_reg(8'h60, "R1"); rd_reg(8'h61, "R1"); rd_reg(8'h70, "R1");
    wr_idx(8'hAA, "R4");
    rd_dat("R4");

    // R2 single key does not unlock
    wr_idx(8'h87, "R2"); rd_dat("R2");
    // R3 interrupted sequence
    wr_idx(8'h55, "R3"); wr_idx(8'h87, "R3"); rd_dat("R3");
    wr_idx(8'h00, "R3");
    // R2 two keys unlock
    unlock("R2");
    rd_reg(8'h20, "R8");

    // R8 identity registers, writes ignored
    rd_reg(8'h21, "R8"); rd_reg(8'h23, "R8"); rd_reg(8'h24, "R8"); rd_reg(8'h26, "R8");
    wr_reg(8'h20, 8'h00, "R8"); rd_dat("R8");
    wr_reg(8'h24, 8'h11, "R8"); rd_dat("R8");

    // R7 banked registers
    wr_reg(8'h07, 8'h03, "R6"); rd_dat("R6");
    wr_reg(8'h30, 8'hFF, "R7"); rd_dat("R7");
    wr_reg(8'h60, 8'h12, "R7"); rd_dat("R7");
    wr_reg(8'h61, 8'h34, "R7"); rd_dat("R7");
    wr_reg(8'h70, 8'hFB, "R7"); rd_dat("R7");
    wr_reg(8'h07, 8'h05, "R7");
    rd_reg(8'h30, "R7"); rd_reg(8'h60, "R7"); rd_reg(8'h70, "R7");
    wr_reg(8'h61, 8'hA5, "R7");
    wr_reg(8'h07, 8'h03, "R7");
    rd_reg(8'h61, "R7"); rd_reg(8'h60, "R7");

    // R6 out-of-range selector
    wr_reg(8'h07, 8'h09, "R6"); rd_dat("R6");
    wr_reg(8'h07, 8'hFF, "R6"); rd_dat("R6");

    // R10 unknown register
    rd_reg(8'h55, "R10"); rd_reg(8'h00, "R10");
    // R4 key byte while open is an index
    wr_idx(8'h87, "R4"); rd_dat("R4");

    // R5 other addresses
    op(1, 0, IDX, 8'h00, "R5");
    op(1, 0, 16'h002F, 8'h00, "R5");
    op(1, 0, 16'h014F, 8'h00, "R5");

    // R9 locked data write clears selector, banks kept
    wr_idx(8'hAA, "R9");
    wr_dat(8'h77, "R9");
    unlock("R9");
    rd_reg(8'h07, "R9");
    wr_reg(8'h07, 8'h03, "R9"); rd_reg(8'h61, "R9");
    // R9 data write while armed
    wr_idx(8'hAA, "R9");
    wr_idx(8'h87, "R9"); wr_dat(8'h01, "R9"); wr_idx(8'h87, "R9");
    rd_reg(8'h07, "R9"); rd_reg(8'h30, "R9");

    // mixed random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      int k, a_sel, v;
      logic [15:0] a;
      logic [7:0]  d;
      k = $urandom_range(0, 9);
      a_sel = $urandom_range(0, 9);
      a = (a_sel < 5) ? IDX : (a_sel < 9) ? DAT : 16'h002E;
      v = $urandom_range(0, 15);
      case (v)
        0, 1, 2: d = 8'h87;
        3: d = 8'hAA;
        4: d = 8'h07;
        5: d = 8'h30;
        6: d = 8'h60;
        7: d = 8'h61;
        8: d = 8'h70;
        9: d = 8'h21;
        10, 11: d = 8'($urandom_range(0, 12));
        default: d = 8'($urandom);
      endcase
      if (k < 4) op(1, 0, a, d, "R5");
      else if (k < 9) op(0, 1, a, d, "R7");
      else op(0, 0, a, d, "R5");
    end

    finish_run();
  end
endmodule